// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Sequencer

The block produces the time-multiplexed drive for a segment LCD with four backplane (common) lines and a parameterised number of segment lines. Every output pin is a 2-bit code naming one of four supply rails. An analog stage outside the block turns that code into a voltage. The display contents come in as a flat 4-column memory vector. The sequencer picks one column per time slot and turns each of its bits into an on or off segment level for that slot.

A mode input sets one of four schemes: static drive, half duty with half bias, third duty with third bias, or quarter duty with third bias. Polarity swaps on every frame, so the panel averages to zero DC. Three inputs force every output to the top rail, which blanks the panel: a software off flag, a standby input and a sync input. Standby also freezes the timing. Sync and a mode change both restart it, so several chips that share a sync pulse stay aligned.

Top module: `lcd_level_seq`

## Requirements
- R1: Level codes are 0 = VDD, 1 = V1, 2 = V2, 3 = V3, from highest to lowest. The mode codes are 0 = static, 1 = half, 2 = third, 3 = quarter. Duty count d = mode+1. Each slot lasts SLOT_CLKS clocks, and slots run 0..d-1 before wrapping.
- R2: Polarity starts at 0 and inverts at the end of each frame, after d slots. At polarity 1 every level is mirrored: VDD↔V3 and V1↔V2.
- R3: At polarity 0, the common whose index equals the current slot drives VDD. The other commons drive V1 in half mode and V2 in third and quarter modes. In static mode all commons follow common 0. At polarity 1 the third-bias levels mirror, while the half-bias idle level stays V1.
- R4: Segment n reads memory bit [slot*NSEG + n]. At polarity 0 an on segment drives V3. An off segment drives V1 in third and quarter modes and VDD in static and half modes. At polarity 1 both levels mirror.
- R5: Memory columns with index ≥ d never affect any output, and commons with index ≥ d always drive their unselected level.
- R6: While lcd_off is 1, every common and segment output is 0 (VDD). The slot timing keeps running during that time.
- R7: While standby is 1, every output is 0 (VDD), and the prescaler, the slot and the polarity all hold their values.
- R8: While sync is 1, every output is 0 (VDD). Each clock edge that sees sync high puts the timing back to slot 0, polarity 0, prescaler 0.
- R9: A clock edge at which mode differs from its value at the previous edge restarts the timing at slot 0, polarity 0.
- R10: After reset, the timing is at slot 0, polarity 0, with mode taken as static.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Duty/bias scheme: 0 static, 1 half, 2 third, 3 quarter |
| lcd_off | input | 1 | Blank the panel while 1 |
| standby | input | 1 | Blank and freeze the timing while 1 |
| sync | input | 1 | Blank and restart the timing while 1 |
| disp_mem | input | 4*NSEG | Display bits, column c at [c*NSEG +: NSEG] |
| com_lvl | output | 2*4 | Level code of each common, common c at [2c +: 2] |
| seg_lvl | output | 2*NSEG | Level code of each segment, segment n at [2n +: 2] |

## Verification
Each of the four modes runs for several frames with random memory contents. This separates the slot walk, the frame-end polarity flip and the per-mode idle levels; half bias is the one case where a level does not mirror. A third-duty run rewrites column 3 on every cycle, which shows that an unused column is never read. Separate runs then pulse lcd_off, standby and sync, and change mode at random instants. A running model of the edge count predicts slot and polarity, so these runs tell apart timing that freezes, timing that keeps running and timing that restarts. A final mixed random run combines all of these inputs.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int NCOM = 4;
  localparam int SW   = 2;

  localparam logic [1:0] LV_VDD = 2'd0;
  localparam logic [1:0] LV_V1  = 2'd1;
  localparam logic [1:0] LV_V2  = 2'd2;
  localparam logic [1:0] LV_V3  = 2'd3;

  // number of slots in one frame for a mode code
  function automatic logic [2:0] duty_of(input logic [1:0] m);
    return {1'b0, m} + 3'd1;
  endfunction

  // level on a backplane line
  function automatic logic [1:0] com_code(input logic [1:0] m, input logic sel,
                                          input logic pol);
    if (m == 2'd0 || sel) return pol ? LV_V3 : LV_VDD;
    if (m == 2'd1)        return LV_V1;
    return pol ? LV_V1 : LV_V2;
  endfunction

  // level on a segment line
  function automatic logic [1:0] seg_code(input logic [1:0] m, input logic on,
                                          input logic pol);
    if (on)        return pol ? LV_VDD : LV_V3;
    if (m >= 2'd2) return pol ? LV_V2 : LV_V1;
    return pol ? LV_V3 : LV_VDD;
  endfunction
endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer
  import lcdseq_pkg::*;
#(
  parameter int SLOT_CLKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                sync,
  input  logic                standby,
  output logic [1:0]          mode_q,
  output logic [SW-1:0]       slot_q,
  output logic                pol_q,
  output logic [NCOM-1:0]     sel_oh
);
  localparam int PW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [PW-1:0] presc_q;
  logic mode_chg, restart, slot_end, last_slot, frame_end;

  assign mode_chg  = (mode != mode_q);
  assign restart   = sync | mode_chg;
  assign slot_end  = (presc_q == PW'(SLOT_CLKS - 1));
  assign last_slot = (slot_q == SW'(duty_of(mode_q) - 3'd1));
  assign frame_end = slot_end & last_slot & ~standby & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      slot_q  <= '0;
      pol_q   <= 1'b0;
      mode_q  <= 2'd0;
    end else begin
      mode_q <= mode;
      if (restart) begin
        presc_q <= '0;
        slot_q  <= '0;
        pol_q   <= 1'b0;
      end else if (!standby) begin
        if (slot_end) begin
          presc_q <= '0;
          if (last_slot) begin
            slot_q <= '0;
            pol_q  <= ~pol_q;
          end else begin
            slot_q <= slot_q + SW'(1);
          end
        end else begin
          presc_q <= presc_q + PW'(1);
        end
      end
    end
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_sel
    assign sel_oh[c] = (slot_q == SW'(c));
  end

  // R1: slot never reaches the duty count of the active mode
  a_r1_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, slot_q} < duty_of(mode_q)));

  // R1: a finished, non-final slot steps to the next one
  a_r1_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !restart && !standby && !last_slot) |=> (slot_q == $past(slot_q) + SW'(1)));

  // R2: polarity only moves at a frame boundary or a restart
  a_r2_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |-> ($past(frame_end) || $past(restart)));

  // R7: standby freezes the timing
  a_r7_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !restart) |=> ($stable(presc_q) && $stable(slot_q) && $stable(pol_q)));

  // R8: sync puts the timing to its origin
  a_r8_sync_origin: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (slot_q == '0 && !pol_q && presc_q == '0));
endmodule

// File: rtl/lcdseq_colmux.sv
module lcdseq_colmux
  import lcdseq_pkg::*;
#(
  parameter int NSEG = 51
) (
  input  logic [NCOM*NSEG-1:0] disp_mem,
  input  logic [SW-1:0]        slot,
  output logic [NSEG-1:0]      col
);
  always_comb begin
    col = '0;
    for (int c = 0; c < NCOM; c++) begin
      if (slot == SW'(c)) col = disp_mem[c*NSEG +: NSEG];
    end
  end
endmodule

// File: rtl/lcdseq_drive.sv
module lcdseq_drive
  import lcdseq_pkg::*;
#(
  parameter int NSEG = 51
) (
  input  logic [1:0]        mode,
  input  logic              pol,
  input  logic              blank,
  input  logic [NCOM-1:0]   sel_oh,
  input  logic [NSEG-1:0]   col,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);
  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = blank ? LV_VDD : com_code(mode, sel_oh[c], pol);
  end
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_lvl[2*s +: 2] = blank ? LV_VDD : seg_code(mode, col[s], pol);
  end
endmodule

// File: rtl/lcd_level_seq.sv
module lcd_level_seq
  import lcdseq_pkg::*;
#(
  parameter int NSEG      = 51,
  parameter int SLOT_CLKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 lcd_off,
  input  logic                 standby,
  input  logic                 sync,
  input  logic [NCOM*NSEG-1:0] disp_mem,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);
  logic [1:0]      mode_q;
  logic [SW-1:0]   slot_q;
  logic            pol_q;
  logic [NCOM-1:0] sel_oh;
  logic [NSEG-1:0] col;
  logic            blank;

  assign blank = lcd_off | standby | sync;

  lcdseq_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sync(sync), .standby(standby),
    .mode_q(mode_q), .slot_q(slot_q), .pol_q(pol_q), .sel_oh(sel_oh)
  );

  lcdseq_colmux #(.NSEG(NSEG)) u_colmux (
    .disp_mem(disp_mem), .slot(slot_q), .col(col)
  );

  lcdseq_drive #(.NSEG(NSEG)) u_drive (
    .mode(mode_q), .pol(pol_q), .blank(blank), .sel_oh(sel_oh), .col(col),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // R6: any blanking input flattens every pin to the top rail
  a_r6_dark_panel: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_off || standby || sync) |-> (com_lvl == '0 && seg_lvl == '0));
endmodule

// File: tb/lcd_level_seq_tb.sv
`timescale 1ns/1ps
module lcd_level_seq_tb;
  localparam int NSEG = 51;
  localparam int NCOM = 4;
  localparam int S    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic lcd_off = 1'b0, standby = 1'b0, sync = 1'b0;
  logic [NCOM*NSEG-1:0] disp_mem = '0;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int errors = 0, checks = 0;
  int n_edges = 0;
  logic [1:0] prev_mode = 2'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_level_seq #(.NSEG(NSEG), .SLOT_CLKS(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lcd_off(lcd_off), .standby(standby),
    .sync(sync), .disp_mem(disp_mem), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // mirror a polarity-0 level for polarity 1
  function automatic logic [1:0] mir(input bit pol, input int x);
    return pol ? 2'(3 - x) : 2'(x);
  endfunction

  function automatic logic [1:0] exp_com(input int m, input bit sel, input bit pol);
    if (m == 0 || sel) return mir(pol, 0);
    if (m == 1) return 2'd1;
    return mir(pol, 2);
  endfunction

  function automatic logic [1:0] exp_seg(input int m, input bit on, input bit pol);
    if (on) return mir(pol, 3);
    if (m >= 2) return mir(pol, 1);
    return mir(pol, 0);
  endfunction

  task automatic check(input string req);
    logic [2*NCOM-1:0] ec;
    logic [2*NSEG-1:0] es;
    int d, slot;
    bit pol, blank;
    d     = int'(prev_mode) + 1;
    slot  = (n_edges / S) % d;
    pol   = bit'((n_edges / (S * d)) % 2);
    blank = lcd_off | standby | sync;
    for (int c = 0; c < NCOM; c++)
      ec[2*c +: 2] = blank ? 2'd0 : exp_com(int'(prev_mode), c == slot, pol);
    for (int s = 0; s < NSEG; s++)
      es[2*s +: 2] = blank ? 2'd0 : exp_seg(int'(prev_mode), disp_mem[slot*NSEG + s], pol);
    checks++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      errors++;
      $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", req, com_lvl, seg_lvl, ec, es);
    end
  endtask

  // one clock: inputs already set, model follows the edge, sample after it
  task automatic tick(input string req);
    @(posedge clk);
    if (!rst_n) begin
      n_edges = 0; prev_mode = 2'd0;
    end else begin
      if (sync || mode != prev_mode) n_edges = 0;
      else if (!standby) n_edges++;
      prev_mode = mode;
    end
    #1;
    check(req);
    @(negedge clk);
  endtask

  task automatic rand_mem();
    for (int i = 0; i < NCOM*NSEG; i++) disp_mem[i] = 1'($urandom % 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rand_mem();
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick("R10 reset");
    rst_n = 1'b1;
    tick("R10 first edge");

    // every mode for several frames
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_mem();
      for (int k = 0; k < 3 * S * (m + 1) + 2; k++) tick("R1 R2 R3 R4 mode sweep");
    end

    // R5: unused column 3 churns under third duty
    mode = 2'd2;
    for (int k = 0; k < 6 * S; k++) begin
      for (int s = 0; s < NSEG; s++) disp_mem[3*NSEG + s] = 1'($urandom % 2);
      tick("R5 masked column");
    end

    // R6: off flag keeps timing running
    mode = 2'd3;
    for (int k = 0; k < 40; k++) begin
      lcd_off = ($urandom % 3) == 0;
      tick("R6 lcd off");
    end
    lcd_off = 1'b0;

    // R7: standby freezes timing
    for (int k = 0; k < 40; k++) begin
      standby = ($urandom % 3) == 0;
      tick("R7 standby");
    end
    standby = 1'b0;

    // R8: sync restarts mid-frame
    for (int k = 0; k < 40; k++) begin
      sync = ($urandom % 7) == 0;
      tick("R8 sync");
    end
    sync = 1'b0;

    // R9: mode changes at arbitrary moments
    for (int k = 0; k < 60; k++) begin
      if (($urandom % 9) == 0) mode = 2'($urandom % 4);
      tick("R9 mode change");
    end

    // mixed random run
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 20) == 0) mode = 2'($urandom % 4);
      lcd_off = ($urandom % 10) == 0;
      standby = ($urandom % 12) == 0;
      sync    = ($urandom % 30) == 0;
      if (($urandom % 25) == 0) rand_mem();
      tick("R3 R4 R6 R7 R8 R9 mixed");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule